// File: doc/BRIEF.md
# Masked Pattern Frame Filter

The filter keeps a short table of pattern words that a host fills one byte at a time. It then judges every received frame against that table. Each word places a 4-byte compare window somewhere in the frame and compares any chosen subset of the four bytes against stored values. A word first passes over a number of whole 4-byte groups of the frame, then opens its window. The windows of consecutive words follow one another, so a few words can pick out sparse fields deep inside a frame.

The host side has a byte write strobe and a write address. The address counts up by itself after each write, so a whole table can be streamed in order. The host can also load the address to patch a single location. An enable level switches the block between loading and filtering. While enable is high the table is frozen and the write address is held at zero.

Frame bytes arrive on a valid/ready stream. Ready equals the enable level and is never lowered for any other reason. While the block is disabled no byte is accepted, so a source must hold its byte and wait. A byte is taken on each rising clock edge where valid and ready are both high. The start and end flags travel with the first and last byte of a frame. One cycle after the last byte is taken, a result strobe and a pass flag appear.

Top module: `pf_frame_filter`

## Requirements
- R1: Each table word w uses the five host addresses 5w to 5w+4. Addresses 5w to 5w+3 hold compare bytes 0 to 3, written lowest byte first. Address 5w+4 is a control byte: bits [3:0] are the byte mask, bits [6:4] are the skip count and bit 7 is the end flag.
- R2: The write address is 0 after reset. It goes up by one after every write strobe taken while disabled, and wraps modulo 64. A load strobe sets it to `host_addr`, and a load wins over the increment in the same cycle. A write in that same cycle still uses the old address.
- R3: Writes to addresses 40 and above change nothing in the table.
- R4: While `host_en` is high, the write address is held at 0 and write and load strobes are ignored. After enable falls, the first write lands at address 0.
- R5: `fr_ready` equals `host_en`. A frame byte is taken only when `fr_valid` and `fr_ready` are both high. `fr_sof` marks the first byte of a frame, which is frame offset 0.
- R6: Word 0's window starts at frame offset 4*skip. Each later word's window starts at (end of the previous window + 1) + 4*skip. A window covers four consecutive offsets.
- R7: If mask bit n is set, the frame byte at window start + n must equal compare byte n. If the bit is clear, that byte is not compared.
- R8: The first word with its end flag set is the final word, and the words after it are not used. If no word has the flag set, word 7 is the final word.
- R9: A frame whose last byte comes before the final word's window is complete fails.
- R10: In the cycle after the end byte is taken, `res_valid` is high for one cycle. `res_pass` is high only if every masked byte of every word up to the final one matched. All match state restarts at each start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Filter enable; low = table load mode |
| host_wr | input | 1 | Table byte write strobe |
| host_wdata | input | 8 | Byte to write |
| host_ld | input | 1 | Write-address load strobe |
| host_addr | input | 6 | Address to load |
| fr_valid | input | 1 | Frame byte valid |
| fr_ready | output | 1 | Frame byte accepted when high with valid |
| fr_sof | input | 1 | Current byte is the first of a frame |
| fr_eof | input | 1 | Current byte is the last of a frame |
| fr_data | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Frame matched the table (valid with res_valid) |

## Verification
The hardest case to reach from the ports is a cumulative window placed deep in the frame. Its position depends on every earlier word's skip count, and a frame cut off just inside the final window has to fail. The bench loads tables whose skip counts add up along the chain. It then sweeps a one-byte corruption across every frame offset and sweeps the frame length through every cut-off point. The expected pass flag for each frame comes from an arithmetic walk of the windows. A second sweep covers every skip and mask pair on a single final word, with the later words filled with conflicting data.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
  localparam int PF_SKIP_W  = 3;
  localparam int PF_LANES   = 4;
  localparam int PF_BPW     = PF_LANES + 1;

  typedef struct packed {
    logic                 eop;
    logic [PF_SKIP_W-1:0] skip;
    logic [PF_LANES-1:0]  mask;
    logic [8*PF_LANES-1:0] val;
  } pf_word_t;
endpackage

// File: rtl/pf_hostport.sv
`timescale 1ns/1ps
module pf_hostport #(
  parameter int NWORDS = 8,
  parameter int AW     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           wr,
  input  logic [7:0]                     wdata,
  input  logic                           ld,
  input  logic [AW-1:0]                  ldaddr,
  output pf_pkg::pf_word_t [NWORDS-1:0]  words
);
  import pf_pkg::*;
  localparam int NBYTES = NWORDS * PF_BPW;

  logic [AW-1:0] addr_q;
  logic [7:0]    mem_q [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (en)     addr_q <= '0;
    else if (ld)     addr_q <= ldaddr;
    else if (wr)     addr_q <= addr_q + 1'b1;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem_q[i] <= '0;
      else if (!en && wr && addr_q == AW'(i))    mem_q[i] <= wdata;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar k = 0; k < PF_LANES; k++) begin : g_lane
      assign words[w].val[8*k +: 8] = mem_q[w*PF_BPW + k];
    end
    assign words[w].mask = mem_q[w*PF_BPW + PF_LANES][PF_LANES-1:0];
    assign words[w].skip = mem_q[w*PF_BPW + PF_LANES][PF_LANES +: PF_SKIP_W];
    assign words[w].eop  = mem_q[w*PF_BPW + PF_LANES][7];
  end

  // R4
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (addr_q == '0));
  // R4
  table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(words));
  // R3
  high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr && addr_q >= AW'(NBYTES)) |=> $stable(words));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr && !ld) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/pf_matcher.sv
`timescale 1ns/1ps
module pf_matcher #(
  parameter int NWORDS = 8,
  parameter int PW     = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  pf_pkg::pf_word_t [NWORDS-1:0]  words,
  input  logic                           fr_valid,
  output logic                           fr_ready,
  input  logic                           fr_sof,
  input  logic                           fr_eof,
  input  logic [7:0]                     fr_data,
  output logic                           res_valid,
  output logic                           res_pass
);
  import pf_pkg::*;
  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [PW-1:0] pos_q, base_q;
  logic [IW-1:0] cur_q;
  logic          fail_q, done_q;
  logic          rv_q, rp_q;

  logic          beat;
  logic [PW-1:0] p, b, ws, off, pos_n, base_n;
  logic [IW-1:0] c, cur_n;
  logic          f, d, fail_n, done_n, in_win, last;
  logic [1:0]    lane;
  logic [7:0]    pbyte;
  pf_word_t      w;

  assign fr_ready = en;
  assign beat     = fr_valid & fr_ready;

  always_comb begin
    p = fr_sof ? '0 : pos_q;
    b = fr_sof ? '0 : base_q;
    c = fr_sof ? '0 : cur_q;
    f = fr_sof ? 1'b0 : fail_q;
    d = fr_sof ? 1'b0 : done_q;
    w      = words[c];
    ws     = b + PW'({w.skip, 2'b00});
    off    = p - ws;
    lane   = off[1:0];
    pbyte  = w.val[{lane, 3'b000} +: 8];
    in_win = !d && (p >= ws) && (p <= ws + PW'(3));
    last   = w.eop || (c == IW'(NWORDS - 1));
    fail_n = f;
    done_n = d;
    cur_n  = c;
    base_n = b;
    if (in_win) begin
      if (w.mask[lane] && fr_data != pbyte) fail_n = 1'b1;
      if (lane == 2'd3) begin
        if (last) done_n = 1'b1;
        else begin
          cur_n  = c + 1'b1;
          base_n = ws + PW'(4);
        end
      end
    end
    pos_n = (&p) ? p : p + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      base_q <= '0;
      cur_q  <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      rp_q   <= 1'b0;
    end else begin
      rv_q <= beat & fr_eof;
      rp_q <= beat & fr_eof & done_n & ~fail_n;
      if (beat) begin
        pos_q  <= pos_n;
        base_q <= base_n;
        cur_q  <= cur_n;
        fail_q <= fail_n;
        done_q <= done_n;
      end
    end
  end

  assign res_valid = rv_q;
  assign res_pass  = rp_q;

  // R10
  res_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fr_valid && fr_ready && fr_eof));
  // R10
  pass_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid);
  // R8
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && beat && !fr_sof) |=> (done_q && $stable(cur_q)));
  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && beat && !fr_sof) |=> fail_q);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(pos_q));
endmodule

// File: rtl/pf_frame_filter.sv
`timescale 1ns/1ps
module pf_frame_filter #(
  parameter int NWORDS = 8,
  parameter int AW     = 6,
  parameter int PW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_ld,
  input  logic [AW-1:0] host_addr,
  input  logic          fr_valid,
  output logic          fr_ready,
  input  logic          fr_sof,
  input  logic          fr_eof,
  input  logic [7:0]    fr_data,
  output logic          res_valid,
  output logic          res_pass
);
  import pf_pkg::*;
  pf_word_t [NWORDS-1:0] words;

  pf_hostport #(.NWORDS(NWORDS), .AW(AW)) u_host (
    .clk(clk), .rst_n(rst_n), .en(host_en), .wr(host_wr),
    .wdata(host_wdata), .ld(host_ld), .ldaddr(host_addr), .words(words)
  );

  pf_matcher #(.NWORDS(NWORDS), .PW(PW)) u_match (
    .clk(clk), .rst_n(rst_n), .en(host_en), .words(words),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_sof(fr_sof),
    .fr_eof(fr_eof), .fr_data(fr_data),
    .res_valid(res_valid), .res_pass(res_pass)
  );
endmodule

// File: tb/sim_pf_frame_filter.sv
`timescale 1ns/1ps
module sim_pf_frame_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_en = 1'b0, host_wr = 1'b0, host_ld = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [5:0] host_addr = '0;
  logic       fr_valid = 1'b0, fr_sof = 1'b0, fr_eof = 1'b0;
  logic [7:0] fr_data = '0;
  logic       fr_ready, res_valid, res_pass;

  always #2.5 clk = ~clk;

  pf_frame_filter u0 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_ld(host_ld), .host_addr(host_addr),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_sof(fr_sof),
    .fr_eof(fr_eof), .fr_data(fr_data),
    .res_valid(res_valid), .res_pass(res_pass)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0]  frm [256];
  logic [31:0] wval [8];
  int wskip [8], wmask [8], weop [8];

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_load(int a);
    @(negedge clk); host_ld = 1'b1; host_addr = 6'(a);
    @(negedge clk); host_ld = 1'b0;
  endtask

  task automatic set_en(bit v);
    @(negedge clk); host_en = v;
    @(negedge clk);
  endtask

  function automatic logic [7:0] ctl_byte(int w);
    return 8'(weop[w] * 128 + wskip[w] * 16 + wmask[w]);
  endfunction

  // R1: five bytes per word, value bytes lowest first, then control
  task automatic load_all();
    set_en(0);
    host_load(0);
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 4; k++) host_write(wval[w][8*k +: 8]);
      host_write(ctl_byte(w));
    end
    set_en(1);
  endtask

  // Take each used word's compare value from the frame at its window (R6)
  task automatic fit_vals(int nuse);
    int base = 0;
    for (int w = 0; w < 8; w++) begin
      if (w < nuse) begin
        int ws = base + 4 * wskip[w];
        wval[w] = {frm[ws+3], frm[ws+2], frm[ws+1], frm[ws]};
        base = ws + 4;
      end else begin
        wval[w] = 32'hC3C3_C3C3 ^ (w * 32'h0101_0101);
      end
    end
  endtask

  function automatic int exp_pass(int len);
    int base = 0;
    for (int w = 0; w < 8; w++) begin
      int ws = base + 4 * wskip[w];
      if (ws + 3 >= len) return 0;
      for (int l = 0; l < 4; l++)
        if (wmask[w][l] && frm[ws+l] != wval[w][8*l +: 8]) return 0;
      if (weop[w] != 0 || w == 7) return 1;
      base = ws + 4;
    end
    return 1;
  endfunction

  task automatic send(int len, string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fr_valid = 1'b1; fr_sof = (i == 0); fr_eof = (i == len - 1);
      fr_data = frm[i];
    end
    @(negedge clk);
    fr_valid = 1'b0; fr_sof = 1'b0; fr_eof = 1'b0;
    chk({req, " R10 strobe"}, int'(res_valid), 1);
    chk(req, int'(res_pass), exp_pass(len));
    @(negedge clk);
    chk("R10 one-cycle strobe", int'(res_valid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) frm[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset strobe", int'(res_valid), 0);
    chk("R5 ready low when disabled", int'(fr_ready), 0);

    // Sparse table: windows at 0,4,12,20,36,40 (R6)
    wskip = '{0, 0, 1, 1, 3, 0, 0, 2};
    wmask = '{15, 3, 12, 2, 9, 3, 15, 15};
    weop  = '{0, 0, 0, 0, 0, 1, 0, 1};
    fit_vals(6);
    load_all();
    chk("R5 ready high when enabled", int'(fr_ready), 1);
    send(48, "R7 full match");
    for (int p = 0; p < 48; p++) begin
      frm[p] ^= 8'h5A;
      send(48, "R7 corrupt sweep");
      frm[p] ^= 8'h5A;
    end
    for (int len = 1; len < 48; len++) send(len, "R9 truncation sweep");

    // R4: writes and loads while enabled are ignored
    host_load(0);
    for (int i = 0; i < 6; i++) host_write(8'h00);
    send(48, "R4 writes while enabled");

    // R4/R2: after enable falls the first write lands at address 0
    set_en(0);
    host_write(frm[0] ^ 8'h01);
    wval[0][7:0] = frm[0] ^ 8'h01;
    set_en(1);
    send(48, "R4 address cleared");

    // R2: address load patches a specific location (word 1 control)
    set_en(0);
    host_load(0);
    host_write(frm[0]);
    wval[0][7:0] = frm[0];
    wmask[1] = 15;
    host_load(9);
    host_write(ctl_byte(1));
    set_en(1);
    send(48, "R2 patched match");
    frm[6] ^= 8'h3C;
    send(48, "R2 patched mask lane");
    frm[6] ^= 8'h3C;

    // R3: writes above the table change nothing
    set_en(0);
    host_load(40);
    for (int i = 0; i < 20; i++) host_write(8'hFF);
    set_en(1);
    send(48, "R3 high writes ignored");

    // R8: no end flag, word 7 is final (windows 0..31)
    wskip = '{0, 0, 0, 0, 0, 0, 0, 0};
    wmask = '{15, 15, 15, 15, 15, 15, 15, 15};
    weop  = '{0, 0, 0, 0, 0, 0, 0, 0};
    fit_vals(8);
    load_all();
    send(32, "R8 no flag full");
    send(31, "R9 no flag short");
    frm[30] ^= 8'h11;
    send(32, "R8 no flag word7 lane");
    frm[30] ^= 8'h11;

    // Single final word: every skip and mask, later words conflicting
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 16; m++) begin
        wskip = '{s, 0, 0, 0, 0, 0, 0, 0};
        wmask = '{m, 15, 15, 15, 15, 15, 15, 15};
        weop  = '{1, 0, 0, 0, 0, 0, 0, 1};
        fit_vals(1);
        load_all();
        send(4 * s + 4, "R8 single word");
        send(4 * s + 3, "R9 single word short");
        for (int l = 0; l < 4; l++) begin
          frm[4*s+l] ^= 8'hA5;
          send(4 * s + 4, "R7 single lane");
          frm[4*s+l] ^= 8'hA5;
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule